// File: doc/BRIEF.md
# Prioritised Address Window Chip-Select Decoder

This block sits beside an external bus sequencer. On every bus cycle it takes the outgoing byte address and compares it with four programmable windows. Each window has a base address, a power-of-two size and an enable. The block then reports which bus configuration governs the cycle: one of the windows, or a catch-all default region. It drives one active-low chip select per window plus one for the default region, so external memories need no glue logic.

The windows may overlap. A fixed ranking settles every overlap: a higher-numbered window always beats a lower-numbered one. The block can also shrink the external address space to 16 MB, 1 MB, 256 KB or 64 KB. Address bits above the chosen space take no part in matching. Only the matching number of upper address lines is passed out of the chip.

The sequencer marks the rising edge of the address-latch strobe with a one-cycle pulse. A decision is captured on that pulse. Its chip select then appears either at that same clock edge or half a clock later, at the following falling edge. All control and address pins are plain level signals. The decoder never stalls the sequencer, so the block has no valid/ready handshake and no back-pressure.

Top module: `cs_window_decoder`

## Requirements
- R1: While `rst_n` is low, every bit of `cs_n` is 1 and `cfg_sel` is 0.
- R2: An enabled window i matches when the effective address and `win_base` agree on every bit at or above position `win_size` (log2 of the window size in bytes). Base bits below that position are ignored. Windows are numbered 1 to 4 and occupy slices 0 to 3 of the packed vectors.
- R3: A window whose `win_en` bit is 0 is never selected, even when the address lies inside it.
- R4: When several enabled windows match, the highest-numbered one wins (4 over 3 over 2 over 1).
- R5: When no enabled window matches, the default region is selected: `cs_n[0]` goes low and `cfg_sel` is 0. Chip select `cs_n[i]` belongs to window i, and `cfg_sel` value i names window i.
- R6: At most one `cs_n` bit is low at any time. One clock after `bus_active` is sampled low, all `cs_n` bits are high and `cfg_sel` is 0. Idle takes precedence over a coincident `latch_rise`.
- R7: With `cs_early` = 1, a decision sampled with `latch_rise` = 1 shows on `cs_n` and `cfg_sel` right after that rising clock edge.
- R8: With `cs_early` = 0, `cfg_sel` still updates at the rising edge, but `cs_n` changes only at the next falling clock edge, half a clock later.
- R9: `space_sel` codes 0/1/2/3 select 16 MB/1 MB/256 KB/64 KB. The address is treated as zero above bit 23/19/17/15 for matching. `addr_hi` passes 8/4/2/0 of the address bits 23:16, starting at bit 16, and drives every other line 0.
- R10: While `bus_active` is 1 and `latch_rise` is 0, `cs_n` and `cfg_sel` keep their values whatever the address does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_active | input | 1 | High while a bus cycle is in progress |
| latch_rise | input | 1 | One-cycle pulse marking the rising edge of the address-latch strobe |
| addr | input | 24 | Byte address of the current cycle |
| win_en | input | NW | Enable per window |
| win_base | input | NW*24 | Packed window base addresses |
| win_size | input | NW*SW | Packed log2 window sizes |
| space_sel | input | 2 | External address space code |
| cs_early | input | 1 | 1: chip selects switch at the rising edge; 0: half a clock later |
| cs_n | output | NW+1 | Active-low chip selects; bit 0 is the default region |
| cfg_sel | output | clog2(NW+1) | Index of the governing configuration |
| addr_hi | output | 8 | Upper address lines leaving the chip |

## Verification
Two things can land in the same clock. The first pair is a latch pulse and an idle bus: the bench raises `latch_rise` in the very cycle it drops `bus_active`, and expects every select high with `cfg_sel` at 0. The second pair is a fresh latch decision arriving while the delayed timing path still shows the previous select. The bench fires back-to-back latch pulses with `cs_early` low. It then samples a quarter clock after each rising edge and expects the previous window's select, and sees the new select only after the falling edge. Its reference model keeps both the latched and the previously shown selection so that it can predict each sample.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;
  localparam int CSD_AW  = 24;
  localparam int CSD_HIW = 8;

  typedef enum logic [1:0] {
    SPACE_16M  = 2'd0,
    SPACE_1M   = 2'd1,
    SPACE_256K = 2'd2,
    SPACE_64K  = 2'd3
  } space_e;

  function automatic int space_lines(space_e s);
    case (s)
      SPACE_16M:  return 8;
      SPACE_1M:   return 4;
      SPACE_256K: return 2;
      default:    return 0;
    endcase
  endfunction
endpackage

// File: rtl/cs_space_limit.sv
module cs_space_limit
  import cs_dec_pkg::*;
#(
  parameter int AW  = CSD_AW,
  parameter int HIW = CSD_HIW
) (
  input  logic [1:0]    space_sel,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] addr_eff,
  output logic [HIW-1:0] addr_hi
);
  localparam int LOW_W = AW - HIW;

  space_e sp;
  int     lines;

  assign sp = space_e'(space_sel);

  always_comb begin
    lines = space_lines(sp);
    for (int b = 0; b < AW; b++)
      addr_eff[b] = (b < LOW_W + lines) ? addr[b] : 1'b0;
    for (int h = 0; h < HIW; h++)
      addr_hi[h] = (h < lines) ? addr[LOW_W + h] : 1'b0;
  end

  always_comb begin
    if (sp == SPACE_64K) begin
      assert_no_upper_lines_R9: assert (addr_hi == '0);
      assert_eff_below_64k_R9:  assert (addr_eff[AW-1:LOW_W] == '0);
    end
  end
endmodule

// File: rtl/cs_win_match.sv
module cs_win_match #(
  parameter int AW = 24,
  parameter int SW = 5
) (
  input  logic          en,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [SW-1:0] size_log,
  output logic          hit
);
  logic [AW-1:0] keep;

  always_comb begin
    for (int b = 0; b < AW; b++)
      keep[b] = (b >= int'(size_log));
    hit = en && (((addr ^ base) & keep) == '0);
  end
endmodule

// File: rtl/cs_prio.sv
module cs_prio #(
  parameter int NW = 4,
  parameter int IW = 3
) (
  input  logic [NW-1:0] hit,
  output logic [NW:0]   dec_oh,
  output logic [IW-1:0] dec_idx
);
  always_comb begin
    dec_oh    = '0;
    dec_oh[0] = 1'b1;
    dec_idx   = '0;
    for (int i = 0; i < NW; i++) begin
      if (hit[i]) begin
        dec_oh        = '0;
        dec_oh[i + 1] = 1'b1;
        dec_idx       = IW'(i + 1);
      end
    end
  end

  always_comb begin
    assert_single_choice_R6: assert ($onehot(dec_oh));
    if (hit[NW-1]) begin
      assert_top_window_wins_R4: assert (dec_idx == IW'(NW));
    end
    if (hit == '0) begin
      assert_fallback_default_R5: assert (dec_oh[0] && dec_idx == '0);
    end
  end
endmodule

// File: rtl/cs_timing.sv
module cs_timing #(
  parameter int NW = 4,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_active,
  input  logic          latch_rise,
  input  logic          cs_early,
  input  logic [NW:0]   dec_oh,
  input  logic [IW-1:0] dec_idx,
  output logic [NW:0]   cs_n,
  output logic [IW-1:0] cfg_sel
);
  logic [NW:0]   sel_q;
  logic [NW:0]   late_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      idx_q <= '0;
    end else if (!bus_active) begin
      sel_q <= '0;
      idx_q <= '0;
    end else if (latch_rise) begin
      sel_q <= dec_oh;
      idx_q <= dec_idx;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) late_q <= '0;
    else        late_q <= sel_q;
  end

  assign cs_n    = ~(cs_early ? sel_q : late_q);
  assign cfg_sel = idx_q;

  assert_idle_all_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_active |=> ((&cs_n) && cfg_sel == '0));

  assert_early_switch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && latch_rise && cs_early) |=> (!cs_early || cs_n == ~$past(dec_oh)));

  assert_late_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    late_q == sel_q);

  assert_hold_between_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && !latch_rise) |=> ($stable(cfg_sel) && $stable(sel_q)));

  assert_at_most_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
endmodule

// File: rtl/cs_window_decoder.sv
module cs_window_decoder
  import cs_dec_pkg::*;
#(
  parameter int NW = 4,
  parameter int SW = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_active,
  input  logic                      latch_rise,
  input  logic [CSD_AW-1:0]         addr,
  input  logic [NW-1:0]             win_en,
  input  logic [NW*CSD_AW-1:0]      win_base,
  input  logic [NW*SW-1:0]          win_size,
  input  logic [1:0]                space_sel,
  input  logic                      cs_early,
  output logic [NW:0]               cs_n,
  output logic [$clog2(NW+1)-1:0]   cfg_sel,
  output logic [CSD_HIW-1:0]        addr_hi
);
  localparam int AW = CSD_AW;
  localparam int IW = $clog2(NW + 1);

  logic [AW-1:0] addr_eff;
  logic [NW-1:0] hit;
  logic [NW:0]   dec_oh;
  logic [IW-1:0] dec_idx;

  cs_space_limit #(.AW(AW), .HIW(CSD_HIW)) u_space (
    .space_sel (space_sel),
    .addr      (addr),
    .addr_eff  (addr_eff),
    .addr_hi   (addr_hi)
  );

  for (genvar i = 0; i < NW; i++) begin : g_win
    cs_win_match #(.AW(AW), .SW(SW)) u_match (
      .en       (win_en[i]),
      .addr     (addr_eff),
      .base     (win_base[i*AW +: AW]),
      .size_log (win_size[i*SW +: SW]),
      .hit      (hit[i])
    );
  end

  cs_prio #(.NW(NW), .IW(IW)) u_prio (
    .hit     (hit),
    .dec_oh  (dec_oh),
    .dec_idx (dec_idx)
  );

  cs_timing #(.NW(NW), .IW(IW)) u_timing (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_active (bus_active),
    .latch_rise (latch_rise),
    .cs_early   (cs_early),
    .dec_oh     (dec_oh),
    .dec_idx    (dec_idx),
    .cs_n       (cs_n),
    .cfg_sel    (cfg_sel)
  );

  always_comb begin
    for (int i = 0; i < NW; i++) begin
      if (!win_en[i]) begin
        assert_off_window_silent_R3: assert (!hit[i]);
      end
    end
  end
endmodule

// File: tb/sim_cs_window_decoder.sv
module sim_cs_window_decoder;
  localparam int PER = 8;
  localparam int NW  = 4;
  localparam int SW  = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_active = 1'b0;
  logic          latch_rise = 1'b0;
  logic [23:0]   addr = '0;
  logic [NW-1:0] win_en = '0;
  logic [1:0]    space_sel = '0;
  logic          cs_early = 1'b1;
  logic [NW*24-1:0] win_base;
  logic [NW*SW-1:0] win_size;
  logic [NW:0]   cs_n;
  logic [2:0]    cfg_sel;
  logic [7:0]    addr_hi;

  logic [23:0] base_a [NW];
  int          sz_a   [NW];
  logic [NW-1:0] nxt_en = 4'hF;
  logic [1:0]  nxt_space = 2'd0;
  logic        nxt_early = 1'b1;

  typedef struct {
    logic [NW:0] cs_n;
    logic [2:0]  sel;
    logic [7:0]  hi;
    string       tag;
  } exp_t;
  exp_t q[$];

  int n_vec = 0;
  int n_bad = 0;
  logic [NW:0] model_oh = '0;
  logic [2:0]  model_idx = '0;

  always #(PER/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < NW; i++) begin
      win_base[i*24 +: 24] = base_a[i];
      win_size[i*SW +: SW] = SW'(sz_a[i]);
    end
  end

  cs_window_decoder #(.NW(NW), .SW(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_active(bus_active), .latch_rise(latch_rise),
    .addr(addr), .win_en(win_en), .win_base(win_base), .win_size(win_size),
    .space_sel(space_sel), .cs_early(cs_early), .cs_n(cs_n), .cfg_sel(cfg_sel),
    .addr_hi(addr_hi)
  );

  function automatic int ref_lines(logic [1:0] s);
    case (s)
      2'd0: return 8;
      2'd1: return 4;
      2'd2: return 2;
      default: return 0;
    endcase
  endfunction

  task automatic ref_dec(input logic [23:0] a, output logic [NW:0] oh, output logic [2:0] idx);
    logic [31:0] am;
    am  = {8'h0, a} & ((32'h1 << (16 + ref_lines(space_sel))) - 32'h1);
    idx = 3'd0;
    for (int i = 0; i < NW; i++)
      if (win_en[i] && ((am >> sz_a[i]) == ({8'h0, base_a[i]} >> sz_a[i])))
        idx = 3'(i + 1);
    oh = (NW+1)'(1) << idx;
  endtask

  task automatic step(input logic [23:0] a, input logic act, input logic rise, input string tag);
    exp_t e;
    logic [NW:0] prev;
    @(negedge clk);
    win_en = nxt_en; space_sel = nxt_space; cs_early = nxt_early;
    addr = a; bus_active = act; latch_rise = rise;
    prev = model_oh;
    if (!act) begin
      model_oh = '0; model_idx = '0;
    end else if (rise) begin
      ref_dec(a, model_oh, model_idx);
    end
    e.cs_n = ~(cs_early ? model_oh : prev);
    e.sel  = model_idx;
    e.hi   = a[23:16] & 8'((32'h1 << ref_lines(space_sel)) - 32'h1);
    e.tag  = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #(PER/4);
      if (q.size() > 0) begin
        e = q.pop_front();
        n_vec++;
        if (cs_n !== e.cs_n || cfg_sel !== e.sel || addr_hi !== e.hi) begin
          n_bad++;
          $display("FAIL %s: cs_n=%b sel=%0d hi=%h expected cs_n=%b sel=%0d hi=%h",
                   e.tag, cs_n, cfg_sel, addr_hi, e.cs_n, e.sel, e.hi);
        end
      end
    end
  end

  initial begin : watchdog
    #(PER * 5000);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : driver
    base_a[0] = 24'h100000; sz_a[0] = 20;
    base_a[1] = 24'h18ABCD; sz_a[1] = 16;
    base_a[2] = 24'h188000; sz_a[2] = 12;
    base_a[3] = 24'h188800; sz_a[3] = 8;
    win_en = 4'hF;
    repeat (3) @(posedge clk);
    #(PER/4);
    n_vec++;
    if (cs_n !== 5'h1F || cfg_sel !== 3'd0) begin
      n_bad++;
      $display("FAIL R1 reset: cs_n=%b sel=%0d expected cs_n=11111 sel=0", cs_n, cfg_sel);
    end
    @(negedge clk); rst_n = 1'b1;

    step(24'h300000, 1, 1, "R5 default region");
    step(24'h100010, 1, 1, "R2 window 1");
    step(24'h180010, 1, 1, "R2 R4 window 2 over 1, base low bits ignored");
    step(24'h188010, 1, 1, "R4 window 3 over 2");
    step(24'h188810, 1, 1, "R4 window 4 over 3");
    step(24'h100000, 1, 0, "R10 hold without latch");
    step(24'h300000, 1, 0, "R10 hold again");
    nxt_en = 4'b0111;
    step(24'h188810, 1, 1, "R3 window 4 disabled");
    step(24'h188810, 0, 1, "R6 idle beats latch");
    step(24'h188810, 1, 0, "R6 still deselected");
    nxt_en = 4'hF; nxt_space = 2'd1;
    step(24'h188810, 1, 1, "R9 1MB space");
    nxt_space = 2'd2;
    step(24'hFF0000, 1, 1, "R9 256KB space");
    nxt_space = 2'd3;
    step(24'hFF0000, 1, 1, "R9 64KB space");
    nxt_space = 2'd0;
    step(24'hFF0000, 1, 1, "R9 16MB space");
    nxt_early = 1'b0;
    step(24'h100010, 1, 1, "R8 late keeps old select");
    step(24'h100010, 1, 0, "R8 late shows window 1");
    step(24'h188810, 1, 1, "R8 late back-to-back");
    step(24'h188810, 1, 0, "R8 late shows window 4");
    step(24'h188810, 0, 0, "R8 R6 late idle");
    step(24'h188810, 0, 0, "R6 late all high");
    nxt_early = 1'b1;
    step(24'h180010, 1, 1, "R7 early switch");
    step(24'h180010, 1, 0, "R7 early held");

    @(negedge clk); latch_rise = 1'b0;
    repeat (3) @(posedge clk);
    #(PER/2);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule